// File: doc/BRIEF.md
# UART Modem Control and Loopback Section

This block is the modem-control and self-test slice of a 16550-style serial port. It holds two control registers: a modem control word and an interrupt-enable word, whose bit 5 unlocks the extended features. From them it drives the transmit line, the two active-low handshake outputs and an external reset line, and it raises a power-down request. It also samples the four active-low modem status inputs and presents them, active-high, to the status logic elsewhere in the UART.

When loopback is selected, the serial output of the transmit shift register goes straight back to the receive shift register input. The transmit pin idles at mark, the handshake outputs go inactive, and the modem inputs are frozen out. The external reset line combines the hardware reset with a software-driven reset intended for an attached device. The software reset never clears this block's own registers.

Top module: `uart_modem_ctl`

## Requirements
- R1: While `hw_reset` is high, both registers read 0, the four status outputs read 0, `rts_n` and `dtr_n` are 1, `pwr_down_req` is 0 and `ext_rst` is 1.
- R2: A write with `wr_en` high loads `wr_data` into the modem control word (`wr_sel`=0) or the interrupt-enable word (`wr_sel`=1) at the next clock edge, and the value appears on `mcr_value` or `ier_value`.
- R3: With loopback off (modem control bit 4 = 0), `rts_n` is the inverse of modem control bit 1 and `dtr_n` is the inverse of modem control bit 0.
- R4: With loopback off, `tx_pin` equals `tsr_bit` and `rsr_bit` equals `rx_pin`.
- R5: With loopback on (modem control bit 4 = 1), `rsr_bit` equals `tsr_bit`, `rx_pin` has no effect, and `tx_pin` is 1.
- R6: With loopback on, `rts_n` and `dtr_n` are both 1 whatever modem control bits 1 and 0 hold.
- R7: With loopback off, each status output (`cts`,`dsr`,`dcd`,`ri`) is the inverse of its input pin as sampled at the previous clock edge; with loopback on, the status outputs hold their values and pin changes have no effect.
- R8: `ext_rst` is high when `hw_reset` is high, or when modem control bit 2 and interrupt-enable bit 5 are both 1; a software reset leaves both registers unchanged.
- R9: `pwr_down_req` is 1 exactly when modem control bit 7 and interrupt-enable bit 5 are both 1; entering or leaving power-down leaves both registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_reset | input | 1 | Hardware reset, active high, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects modem control, 1 selects interrupt enable |
| wr_data | input | 8 | Write data |
| mcr_value | output | 8 | Modem control word |
| ier_value | output | 8 | Interrupt-enable word |
| tsr_bit | input | 1 | Serial output of transmit shift register |
| rsr_bit | output | 1 | Serial input to receive shift register |
| rx_pin | input | 1 | Receive data pin |
| tx_pin | output | 1 | Transmit data pin |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Terminal-ready, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Set-ready pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| ri_n | input | 1 | Ring pin, active low |
| cts | output | 1 | Sampled clear-to-send status |
| dsr | output | 1 | Sampled set-ready status |
| dcd | output | 1 | Sampled carrier-detect status |
| ri | output | 1 | Sampled ring status |
| ext_rst | output | 1 | Reset to the external device |
| pwr_down_req | output | 1 | Power-down request |

## Verification
A corrupted control register shows up on the pins in the same cycle it is wrong. The transmit, handshake, reset and power-down outputs are all combinational decodes of the registers. Any stray register change is therefore visible at the next falling edge. A wrong status sample, or a sample that leaks through during loopback, appears on the status outputs one edge after the pin moves. The bench toggles the modem pins while loopback is on, so that such a leak reaches the outputs.

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          hw_reset,
  input  logic          wr_en,
  input  logic          wr_sel,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] mcr_value,
  output logic [DW-1:0] ier_value,
  input  logic          tsr_bit,
  output logic          rsr_bit,
  input  logic          rx_pin,
  output logic          tx_pin,
  output logic          rts_n,
  output logic          dtr_n,
  input  logic          cts_n,
  input  logic          dsr_n,
  input  logic          dcd_n,
  input  logic          ri_n,
  output logic          cts,
  output logic          dsr,
  output logic          dcd,
  output logic          ri,
  output logic          ext_rst,
  output logic          pwr_down_req
);

  localparam int B_DTR  = 0;
  localparam int B_RTS  = 1;
  localparam int B_SRST = 2;
  localparam int B_LOOP = 4;
  localparam int B_PD   = 7;
  localparam int B_EXT  = 5;

  logic [DW-1:0] mcr_q, ier_q;
  logic [3:0]    stat_q;
  logic          loop, ext_on;

  always_ff @(posedge clk or posedge hw_reset) begin
    if (hw_reset) begin
      mcr_q <= '0;
      ier_q <= '0;
    end else if (wr_en) begin
      if (wr_sel) ier_q <= wr_data;
      else        mcr_q <= wr_data;
    end
  end

  always_ff @(posedge clk or posedge hw_reset) begin
    if (hw_reset)   stat_q <= '0;
    else if (!loop) stat_q <= ~{cts_n, dsr_n, dcd_n, ri_n};
  end

  assign loop   = mcr_q[B_LOOP];
  assign ext_on = ier_q[B_EXT];

  assign tx_pin  = loop | tsr_bit;
  assign rsr_bit = loop ? tsr_bit : rx_pin;
  assign rts_n   = loop | ~mcr_q[B_RTS];
  assign dtr_n   = loop | ~mcr_q[B_DTR];

  assign ext_rst      = hw_reset | (ext_on & mcr_q[B_SRST]);
  assign pwr_down_req = ext_on & mcr_q[B_PD];

  assign {cts, dsr, dcd, ri} = stat_q;
  assign mcr_value = mcr_q;
  assign ier_value = ier_q;

endmodule

module uart_modem_ctl_chk (
  input logic       clk,
  input logic       hw_reset,
  input logic       wr_en,
  input logic [7:0] mcr_value,
  input logic [7:0] ier_value,
  input logic       tsr_bit,
  input logic       rsr_bit,
  input logic       tx_pin,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       cts_n,
  input logic       cts,
  input logic       dsr,
  input logic       dcd,
  input logic       ri,
  input logic       ext_rst,
  input logic       pwr_down_req
);

  p_reset_state_r1: assert property (@(posedge clk)
    hw_reset |-> (ext_rst && !pwr_down_req && rts_n && dtr_n));

  p_hold_regs_r2: assert property (@(posedge clk) disable iff (hw_reset)
    !$past(wr_en) |-> ($stable(mcr_value) && $stable(ier_value)));

  p_loop_path_r5: assert property (@(posedge clk) disable iff (hw_reset)
    mcr_value[4] |-> (tx_pin && rsr_bit == tsr_bit));

  p_loop_quiet_r6: assert property (@(posedge clk) disable iff (hw_reset)
    mcr_value[4] |-> (rts_n && dtr_n));

  p_status_frozen_r7: assert property (@(posedge clk) disable iff (hw_reset)
    ($past(mcr_value[4]) && !$past(hw_reset)) |-> ($stable(cts) && $stable(dsr) && $stable(dcd) && $stable(ri)));

  p_status_sample_r7: assert property (@(posedge clk) disable iff (hw_reset)
    (!$past(mcr_value[4]) && !$past(hw_reset)) |-> (cts == !$past(cts_n)));

  p_soft_rst_r8: assert property (@(posedge clk) disable iff (hw_reset)
    (mcr_value[2] && ier_value[5]) |-> ext_rst);

  p_pd_gated_r9: assert property (@(posedge clk) disable iff (hw_reset)
    pwr_down_req |-> (ier_value[5] && mcr_value[7]));

endmodule

bind uart_modem_ctl uart_modem_ctl_chk chk_i (.*);

// File: tb/uart_modem_ctl_tb.sv
module uart_modem_ctl_tb_top;
  logic clk = 0;
  logic hw_reset, wr_en, wr_sel, tsr_bit, rx_pin, cts_n, dsr_n, dcd_n, ri_n;
  logic [7:0] wr_data, mcr_value, ier_value;
  logic rsr_bit, tx_pin, rts_n, dtr_n, cts, dsr, dcd, ri, ext_rst, pwr_down_req;

  always #2 clk = ~clk;

  uart_modem_ctl dut_i (.*);

  typedef struct { string tag; logic [25:0] exp; } item_t;
  item_t sbq[$];
  int checks = 0, errors = 0, cycles = 0;

  logic [7:0] m_mcr = 0, m_ier = 0;
  logic [3:0] m_stat = 0;

  function automatic logic [25:0] actual();
    return {tx_pin, rsr_bit, rts_n, dtr_n, ext_rst, pwr_down_req,
            cts, dsr, dcd, ri, mcr_value, ier_value};
  endfunction

  task automatic step(string tag, logic rst, logic we, logic sel, logic [7:0] d,
                      logic tb, logic rx, logic [3:0] mpins);
    item_t it;
    logic lp, en;
    @(posedge clk); #1;
    hw_reset = rst; wr_en = we; wr_sel = sel; wr_data = d;
    tsr_bit = tb; rx_pin = rx; {cts_n, dsr_n, dcd_n, ri_n} = mpins;
    if (rst) begin m_mcr = 0; m_ier = 0; m_stat = 0; end
    lp = m_mcr[4]; en = m_ier[5];
    it.tag = tag;
    it.exp = {lp | tb, lp ? tb : rx, lp | ~m_mcr[1], lp | ~m_mcr[0],
              rst | (en & m_mcr[2]), en & m_mcr[7], m_stat, m_mcr, m_ier};
    sbq.push_back(it);
    if (!rst) begin
      if (!lp) m_stat = ~mpins;
      if (we) begin if (sel) m_ier = d; else m_mcr = d; end
    end
  endtask

  always @(negedge clk) begin
    if (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if (actual() !== it.exp) begin
        errors++;
        $display("FAIL %s actual=%h expected=%h", it.tag, actual(), it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    hw_reset = 1; wr_en = 0; wr_sel = 0; wr_data = 0;
    tsr_bit = 1; rx_pin = 1; {cts_n, dsr_n, dcd_n, ri_n} = 4'hF;
    step("R1 reset", 1, 1, 0, 8'hFF, 0, 0, 4'h0);
    step("R1 reset hold", 1, 0, 0, 0, 1, 0, 4'h5);
    step("R3 write mcr", 0, 1, 0, 8'h03, 1, 1, 4'hF);
    step("R2 R3 mcr seen", 0, 0, 0, 0, 0, 1, 4'hF);
    step("R3 rts only", 0, 1, 0, 8'h02, 1, 0, 4'h0);
    step("R4 tx/rx pass", 0, 0, 0, 0, 0, 1, 4'hA);
    step("R4 tx/rx pass b", 0, 0, 0, 0, 1, 0, 4'h5);
    step("R7 sample", 0, 0, 0, 0, 1, 1, 4'h3);
    step("R7 sample b", 0, 0, 0, 0, 1, 1, 4'hC);
    step("R5 enter loop", 0, 1, 0, 8'h13, 0, 1, 4'hC);
    step("R5 R6 loop a", 0, 0, 0, 0, 0, 1, 4'h0);
    step("R5 R7 loop b", 0, 0, 0, 0, 1, 0, 4'hF);
    step("R5 R7 loop c", 0, 0, 0, 0, 0, 0, 4'h6);
    step("R6 leave loop", 0, 1, 0, 8'h03, 1, 0, 4'h9);
    step("R7 resume", 0, 0, 0, 0, 1, 1, 4'h9);
    step("R8 srst no enable", 0, 1, 0, 8'h04, 1, 1, 4'hF);
    step("R8 srst gated", 0, 1, 1, 8'h20, 1, 1, 4'hF);
    step("R8 srst active", 0, 0, 0, 0, 1, 1, 4'hF);
    step("R8 regs kept", 0, 0, 0, 0, 0, 1, 4'hF);
    step("R9 pd req", 0, 1, 0, 8'h84, 1, 1, 4'hF);
    step("R9 pd active", 0, 0, 0, 0, 1, 0, 4'h7);
    step("R9 pd drop", 0, 1, 1, 8'h00, 1, 1, 4'hF);
    step("R9 regs kept", 0, 0, 0, 0, 1, 1, 4'hF);
    step("R1 reset again", 1, 0, 0, 0, 1, 1, 4'h0);
    step("R1 after reset", 0, 0, 0, 0, 1, 1, 4'hF);
    step("R2 idle", 0, 0, 0, 0, 1, 1, 4'hF);
    repeat (3) @(posedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule